// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge is a bus slave that sits in front of a downstream memory port and decodes a 32 MB alias window. Every 4-byte-spaced alias word stands for a single bit of a real memory region that starts at a configurable base. A read of an alias word returns that one bit as 0 or 1. A write to an alias word sets or clears only that bit, using a locked read-modify-write of the backing memory. All other bits of the backing memory stay as they were.

An upstream master issues a request with an address, a write flag, an access size (byte, halfword or word) and write data. It holds the request until `s_ready` pulses for one cycle with the response. Downstream, the bridge issues one-cycle requests and waits for an acknowledge. It asserts a lock for the whole read-modify-write, so that no other master can slip an access in between the two phases.

The sequencing is done by a finite-state machine with these states:
- `ST_IDLE`: a request is captured here, and the machine moves to `ST_RD_REQ`.
- `ST_RD_REQ`: moves to `ST_RD_WAIT`.
- `ST_RD_WAIT`: on an acknowledge it goes to `ST_RESP` if the access is a read or the acknowledge carries an error, and to `ST_WR_REQ` for an error-free write.
- `ST_WR_REQ`: moves to `ST_WR_WAIT`.
- `ST_WR_WAIT`: on an acknowledge it moves to `ST_RESP`.
- `ST_RESP`: drives `s_ready` and returns to `ST_IDLE`.

Top module: `bitband_bridge`

## Requirements
- R1: Only bits [24:0] of `s_addr` form the window offset. Higher address bits have no effect on the downstream address or on the result.
- R2: The downstream byte address is `REAL_BASE | (offset >> 5)`, aligned by size:
  - byte: unchanged
  - halfword: bit 0 cleared
  - word: bits [1:0] cleared

  `m_size` repeats the access size. The size encoding is 0 = byte, 1 = halfword, 2 = word, and 3 is treated as word.
- R3: The selected bit within the access unit is:
  - byte: offset[4:2]
  - halfword: offset[5:2]
  - word: offset[6:2]

  Lanes are little-endian on the 32-bit data bus. The byte-enables `m_be` cover exactly the lanes of the access unit: 1 << addr[1:0] for a byte, 4'b0011 or 4'b1100 for a halfword, and 4'b1111 for a word.
- R4: A read returns, in bit 0 of `s_rdata`, the state of the selected bit. All other bits of `s_rdata` are zero, and `s_err` is 0. A write returns zero data.
- R5: A write first reads the backing unit, then writes the same address, size and byte-enables. In the written data the selected bit equals `s_wdata[0]` and every other bit is unchanged.
- R6: `m_lock` is high continuously from the read request of a write until that write is acknowledged. It is low for read-only accesses and whenever `s_ready` is high.
- R7: An error acknowledge in the read phase aborts the access: no write request follows, `s_err` is 1 and `s_rdata` is zero. An error in the write phase is also reported on `s_err`.
- R8: After reset, `s_ready`, `m_req` and `m_lock` are low. `s_ready` is high for exactly one cycle per transfer.
- R9: Each phase issues `m_req` for exactly one cycle. The response arrives 2+L cycles after the request for a read and 3+2L cycles for a write, where L is the downstream acknowledge latency in cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_req | input | 1 | Upstream request, held until `s_ready` |
| s_addr | input | 32 | Alias address |
| s_we | input | 1 | 1 = write, 0 = read |
| s_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| s_wdata | input | 32 | Write data; bit 0 is the new bit value |
| s_ready | output | 1 | One-cycle response strobe |
| s_rdata | output | 32 | Read result: selected bit in bit 0 |
| s_err | output | 1 | Error reported with the response |
| m_req | output | 1 | Downstream request, one cycle per phase |
| m_we | output | 1 | Downstream write flag |
| m_lock | output | 1 | Held across a read-modify-write |
| m_addr | output | 32 | Downstream byte address, size-aligned |
| m_size | output | 2 | Downstream access size |
| m_be | output | 4 | Downstream byte-enables |
| m_wdata | output | 32 | Downstream write data on little-endian lanes |
| m_ack | input | 1 | Downstream acknowledge, one cycle |
| m_rdata | input | 32 | Downstream read data, valid with `m_ack` |
| m_err | input | 1 | Downstream error, valid with `m_ack` |

## Verification
The bench covers three kinds of bit selection, and each has a typical failure:
- Halfword accesses whose bit index is 8 or above spill into the next real byte. A bridge that forgets the even-address forcing would target the wrong halfword.
- Word accesses at bit 31 catch a bit position that drops the lane bits.
- An alias address with bits 25 to 31 all set shows whether upper address bits leak into the backing address.

For writes, the bench checks:
- The neighbouring bits in a byte, a halfword and a word survive the write. A merge that reused stale data or the wrong mask would corrupt them.
- Write data with bit 0 clear but other bits set still clears the selected bit.
- The lock covers both phases.

For errors, a read-phase error on a write must suppress the write entirely. A bridge that ignored the error would still modify memory. The bench also checks the response latencies at two acknowledge delays, which catches extra or missing states.

// File: rtl/bb_pkg.sv
package bb_pkg;

    localparam int BUS_W = 32;
    localparam int LANES = BUS_W / 8;
    localparam int POS_W = $clog2(BUS_W);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } bb_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_WR_REQ,
        ST_WR_WAIT,
        ST_RESP
    } bb_state_e;

endpackage

// File: rtl/bb_addr_map.sv
module bb_addr_map
    import bb_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter int              WIN_BITS  = 25,
    parameter logic [ADDR_W-1:0] REAL_BASE = 32'h2000_0000
) (
    input  logic [WIN_BITS-3:0] word_idx,
    input  logic [1:0]          size,
    output logic [ADDR_W-1:0]   back_addr,
    output logic [LANES-1:0]    be,
    output logic [POS_W-1:0]    bit_pos
);

    // Eight alias words map onto one real byte.
    logic [ADDR_W-1:0] raw;
    assign raw = REAL_BASE | ADDR_W'(word_idx >> 3);

    always_comb begin
        unique case (bb_size_e'(size))
            SZ_BYTE: begin
                back_addr = raw;
                be        = LANES'(1) << raw[1:0];
                bit_pos   = {raw[1:0], word_idx[2:0]};
            end
            SZ_HALF: begin
                back_addr = {raw[ADDR_W-1:1], 1'b0};
                be        = raw[1] ? 4'b1100 : 4'b0011;
                bit_pos   = {raw[1], word_idx[3:0]};
            end
            default: begin
                back_addr = {raw[ADDR_W-1:2], 2'b00};
                be        = '1;
                bit_pos   = word_idx[4:0];
            end
        endcase
    end

endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge
    import bb_pkg::*;
(
    input  logic [BUS_W-1:0] word,
    input  logic [POS_W-1:0] bit_pos,
    input  logic             new_val,
    output logic             bit_out,
    output logic [BUS_W-1:0] merged
);

    logic [BUS_W-1:0] mask;

    always_comb begin
        mask    = BUS_W'(1) << bit_pos;
        bit_out = |(word & mask);
        merged  = new_val ? (word | mask) : (word & ~mask);
    end

endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl
    import bb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      s_req,
    input  logic      cap_we,
    input  logic      m_ack,
    input  logic      m_err,
    output bb_state_e state,
    output logic      cap_en,
    output logic      rd_load,
    output logic      err_set,
    output logic      m_req,
    output logic      m_we,
    output logic      m_lock,
    output logic      s_ready
);

    bb_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (s_req) nxt = ST_RD_REQ;
            ST_RD_REQ:  nxt = ST_RD_WAIT;
            ST_RD_WAIT: if (m_ack) nxt = (m_err || !cap_we) ? ST_RESP : ST_WR_REQ;
            ST_WR_REQ:  nxt = ST_WR_WAIT;
            ST_WR_WAIT: if (m_ack) nxt = ST_RESP;
            ST_RESP:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        cap_en  = 1'b0;
        rd_load = 1'b0;
        err_set = 1'b0;
        m_req   = 1'b0;
        m_we    = 1'b0;
        m_lock  = 1'b0;
        s_ready = 1'b0;
        unique case (state)
            ST_IDLE:    cap_en = s_req;
            ST_RD_REQ: begin
                m_req  = 1'b1;
                m_lock = cap_we;
            end
            ST_RD_WAIT: begin
                m_lock  = cap_we;
                rd_load = m_ack && !m_err;
                err_set = m_ack && m_err;
            end
            ST_WR_REQ: begin
                m_req  = 1'b1;
                m_we   = 1'b1;
                m_lock = 1'b1;
            end
            ST_WR_WAIT: begin
                m_we    = 1'b1;
                m_lock  = 1'b1;
                err_set = m_ack && m_err;
            end
            ST_RESP:    s_ready = 1'b1;
            default:    ;
        endcase
    end

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
    import bb_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter int              WIN_BITS  = 25,
    parameter logic [ADDR_W-1:0] REAL_BASE = 32'h2000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_req,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic              s_we,
    input  logic [1:0]        s_size,
    input  logic [BUS_W-1:0]  s_wdata,
    output logic              s_ready,
    output logic [BUS_W-1:0]  s_rdata,
    output logic              s_err,
    output logic              m_req,
    output logic              m_we,
    output logic              m_lock,
    output logic [ADDR_W-1:0] m_addr,
    output logic [1:0]        m_size,
    output logic [LANES-1:0]  m_be,
    output logic [BUS_W-1:0]  m_wdata,
    input  logic              m_ack,
    input  logic [BUS_W-1:0]  m_rdata,
    input  logic              m_err
);

    localparam int IDX_W = WIN_BITS - 2;

    bb_state_e         state;
    logic              cap_en, rd_load, err_set;
    logic [IDX_W-1:0]  cap_idx;
    logic [1:0]        cap_size;
    logic              cap_we, cap_wbit;
    logic [BUS_W-1:0]  rd_word;
    logic              resp_err;
    logic [POS_W-1:0]  bit_pos;
    logic              sel_bit;
    logic              unused_bits;

    assign unused_bits = ^{s_addr[ADDR_W-1:WIN_BITS], s_addr[1:0], s_wdata[BUS_W-1:1], state};

    bb_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_req   (s_req),
        .cap_we  (cap_we),
        .m_ack   (m_ack),
        .m_err   (m_err),
        .state   (state),
        .cap_en  (cap_en),
        .rd_load (rd_load),
        .err_set (err_set),
        .m_req   (m_req),
        .m_we    (m_we),
        .m_lock  (m_lock),
        .s_ready (s_ready)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_idx  <= '0;
            cap_size <= 2'd0;
            cap_we   <= 1'b0;
            cap_wbit <= 1'b0;
            rd_word  <= '0;
            resp_err <= 1'b0;
        end else begin
            if (cap_en) begin
                cap_idx  <= s_addr[WIN_BITS-1:2];
                cap_size <= s_size;
                cap_we   <= s_we;
                cap_wbit <= s_wdata[0];
                resp_err <= 1'b0;
            end
            if (rd_load) rd_word  <= m_rdata;
            if (err_set) resp_err <= 1'b1;
        end
    end

    bb_addr_map #(
        .ADDR_W   (ADDR_W),
        .WIN_BITS (WIN_BITS),
        .REAL_BASE(REAL_BASE)
    ) u_map (
        .word_idx (cap_idx),
        .size     (cap_size),
        .back_addr(m_addr),
        .be       (m_be),
        .bit_pos  (bit_pos)
    );

    bb_bit_merge u_merge (
        .word    (rd_word),
        .bit_pos (bit_pos),
        .new_val (cap_wbit),
        .bit_out (sel_bit),
        .merged  (m_wdata)
    );

    assign m_size  = cap_size;
    assign s_err   = s_ready && resp_err;
    assign s_rdata = {{(BUS_W-1){1'b0}}, s_ready && !cap_we && !resp_err && sel_bit};

endmodule

// File: rtl/bb_checker.sv
module bb_checker #(
    parameter int              ADDR_W    = 32,
    parameter int              WIN_BITS  = 25,
    parameter logic [ADDR_W-1:0] REAL_BASE = 32'h2000_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_ready,
    input logic              m_req,
    input logic              m_we,
    input logic              m_lock,
    input logic              m_ack,
    input logic              m_err,
    input logic [ADDR_W-1:0] m_addr,
    input logic [1:0]        m_size
);

    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << (WIN_BITS - 5)) - 1);

    p_ready_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready);

    p_req_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |=> !m_req);

    p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_lock && !m_ack) |=> m_lock);

    p_write_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_we) |-> m_lock);

    p_resp_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> !m_lock);

    p_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> ((m_size == 2'd1) ? !m_addr[0] :
                   (m_size == 2'd0) ? 1'b1 : (m_addr[1:0] == 2'b00)));

    p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> ((m_addr | LOW_MASK) == (REAL_BASE | LOW_MASK)));

    p_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_ack && m_err && !m_we) |=> !m_req);

endmodule

bind bitband_bridge bb_checker #(
    .ADDR_W   (ADDR_W),
    .WIN_BITS (WIN_BITS),
    .REAL_BASE(REAL_BASE)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_ready (s_ready),
    .m_req   (m_req),
    .m_we    (m_we),
    .m_lock  (m_lock),
    .m_ack   (m_ack),
    .m_err   (m_err),
    .m_addr  (m_addr),
    .m_size  (m_size)
);

// File: tb/bitband_bridge_tb_top.sv
`timescale 1ns/1ps
module bitband_bridge_tb_top;

    localparam logic [31:0] ALIAS = 32'h2200_0000;
    localparam logic [31:0] REAL  = 32'h2000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_req = 1'b0, s_we = 1'b0;
    logic [31:0] s_addr = '0, s_wdata = '0;
    logic [1:0]  s_size = 2'd0;
    logic        s_ready, s_err;
    logic [31:0] s_rdata;
    logic        m_req, m_we, m_lock;
    logic [31:0] m_addr, m_wdata;
    logic [1:0]  m_size;
    logic [3:0]  m_be;
    logic        m_ack = 1'b0, m_err = 1'b0;
    logic [31:0] m_rdata = '0;

    int n_tests = 0, n_fail = 0;
    logic [31:0] mem [0:63];
    int          lat = 1;
    bit          err_rd = 0, err_wr = 0;
    int          n_req = 0, n_wr = 0;
    logic [31:0] last_addr;
    logic [3:0]  last_be;
    logic [1:0]  last_size;
    logic        lock_rd, lock_wr;

    always #2 clk = ~clk;

    bitband_bridge dut_i (
        .clk(clk), .rst_n(rst_n),
        .s_req(s_req), .s_addr(s_addr), .s_we(s_we), .s_size(s_size), .s_wdata(s_wdata),
        .s_ready(s_ready), .s_rdata(s_rdata), .s_err(s_err),
        .m_req(m_req), .m_we(m_we), .m_lock(m_lock), .m_addr(m_addr), .m_size(m_size),
        .m_be(m_be), .m_wdata(m_wdata), .m_ack(m_ack), .m_rdata(m_rdata), .m_err(m_err)
    );

    // Downstream memory model, driven on falling edges.
    initial begin
        @(negedge clk);
        forever begin
            if (m_req) begin
                n_req++;
                last_addr = m_addr;
                last_be   = m_be;
                last_size = m_size;
                if (m_we) begin
                    n_wr++;
                    lock_wr = m_lock;
                end else begin
                    lock_rd = m_lock;
                end
                begin
                    logic        we_l;
                    logic [31:0] wd_l;
                    logic [3:0]  be_l;
                    logic [5:0]  ix;
                    we_l = m_we;
                    wd_l = m_wdata;
                    be_l = m_be;
                    ix   = m_addr[7:2];
                    repeat (lat) @(negedge clk);
                    m_ack   = 1'b1;
                    m_err   = we_l ? err_wr : err_rd;
                    m_rdata = mem[ix];
                    if (we_l && !m_err)
                        for (int b = 0; b < 4; b++)
                            if (be_l[b]) mem[ix][8*b +: 8] = wd_l[8*b +: 8];
                end
                @(negedge clk);
                m_ack = 1'b0;
                m_err = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    end

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] a, input bit we, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output logic er, output int cyc);
        @(negedge clk);
        s_req = 1'b1; s_addr = a; s_we = we; s_size = sz; s_wdata = wd;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!s_ready && cyc < 300);
        if (cyc >= 300) chk("R8 watchdog", 32'(cyc), 32'd0);
        rd = s_rdata;
        er = s_err;
        s_req = 1'b0;
    endtask

    function automatic logic [31:0] al(input int real_off, input int k);
        return ALIAS + 32'(real_off * 32) + 32'(k * 4);
    endfunction

    task automatic t_reset();
        chk("R8 reset s_ready", 32'(s_ready), 0);
        chk("R8 reset m_req", 32'(m_req), 0);
        chk("R8 reset m_lock", 32'(m_lock), 0);
    endtask

    task automatic t_byte_read();
        logic [31:0] rd; logic er; int c;
        mem[1] = 32'h0000_A500;
        access(al(5, 0), 0, 2'd0, 0, rd, er, c);
        chk("R4 byte bit0", rd, 1);
        chk("R4 err", 32'(er), 0);
        chk("R2 byte addr", last_addr, REAL + 5);
        chk("R3 byte be", 32'(last_be), 32'b0010);
        access(al(5, 1), 0, 2'd0, 0, rd, er, c);
        chk("R4 byte bit1", rd, 0);
        access(al(5, 7), 0, 2'd0, 0, rd, er, c);
        chk("R3 byte bit7", rd, 1);
        chk("R6 read unlocked", 32'(lock_rd), 0);
    endtask

    task automatic t_half_read();
        logic [31:0] rd; logic er; int c;
        mem[2] = 32'h8001_0000;
        access(al(10, 15), 0, 2'd1, 0, rd, er, c);
        chk("R3 half bit15", rd, 1);
        chk("R2 half addr even", last_addr, REAL + 10);
        chk("R3 half be", 32'(last_be), 32'b1100);
        chk("R2 half size", 32'(last_size), 1);
        access(al(10, 1), 0, 2'd1, 0, rd, er, c);
        chk("R3 half bit1", rd, 0);
        access(al(10, 0), 0, 2'd1, 0, rd, er, c);
        chk("R3 half bit0", rd, 1);
    endtask

    task automatic t_word_read();
        logic [31:0] rd; logic er; int c;
        mem[3] = 32'h8000_0010;
        access(al(12, 31), 0, 2'd2, 0, rd, er, c);
        chk("R3 word bit31", rd, 1);
        chk("R2 word addr", last_addr, REAL + 12);
        chk("R3 word be", 32'(last_be), 32'hF);
        access(al(12, 5), 0, 2'd2, 0, rd, er, c);
        chk("R4 word bit5", rd, 0);
        access(al(12, 4), 0, 2'd2, 0, rd, er, c);
        chk("R4 word bit4", rd, 1);
    endtask

    task automatic t_upper_ignored();
        logic [31:0] rd; logic er; int c;
        access(32'hFE00_0000 | (al(12, 31) & 32'h01FF_FFFF), 0, 2'd2, 0, rd, er, c);
        chk("R1 upper bits result", rd, 1);
        chk("R1 upper bits addr", last_addr, REAL + 12);
    endtask

    task automatic t_byte_write();
        logic [31:0] rd; logic er; int c; int w0;
        mem[4] = 32'h1234_5678;
        w0 = n_wr;
        access(al(17, 3), 1, 2'd0, 32'h1, rd, er, c);
        chk("R5 byte set merge", mem[4], 32'h1234_5E78);
        chk("R5 one write", 32'(n_wr - w0), 1);
        chk("R5 write addr", last_addr, REAL + 17);
        chk("R5 write be", 32'(last_be), 32'b0010);
        chk("R6 lock read phase", 32'(lock_rd), 1);
        chk("R6 lock write phase", 32'(lock_wr), 1);
        chk("R4 write rdata", rd, 0);
        chk("R9 write latency", 32'(c), 32'(3 + 2 * lat));
    endtask

    task automatic t_word_clear();
        logic [31:0] rd; logic er; int c;
        mem[5] = 32'hFFFF_FFFF;
        access(al(20, 31), 1, 2'd2, 32'hFFFF_FFFE, rd, er, c);
        chk("R5 word clear bit31", mem[5], 32'h7FFF_FFFF);
    endtask

    task automatic t_half_set();
        logic [31:0] rd; logic er; int c;
        mem[6] = 32'h0000_0000;
        access(al(26, 9), 1, 2'd1, 32'h1, rd, er, c);
        chk("R3 half write lane", mem[6], 32'h0200_0000);
        chk("R5 half write be", 32'(last_be), 32'b1100);
    endtask

    task automatic t_errors();
        logic [31:0] rd; logic er; int c; int w0; int q0;
        mem[7] = 32'hAAAA_AAAA;
        err_rd = 1;
        w0 = n_wr;
        access(al(28, 0), 1, 2'd2, 32'h1, rd, er, c);
        chk("R7 read-phase err flag", 32'(er), 1);
        chk("R7 no write phase", 32'(n_wr - w0), 0);
        chk("R7 mem untouched", mem[7], 32'hAAAA_AAAA);
        q0 = n_req;
        access(al(28, 1), 0, 2'd2, 0, rd, er, c);
        chk("R7 read err flag", 32'(er), 1);
        chk("R7 read err data", rd, 0);
        chk("R9 read single request", 32'(n_req - q0), 1);
        err_rd = 0;
        err_wr = 1;
        access(al(28, 0), 1, 2'd2, 32'h1, rd, er, c);
        chk("R7 write-phase err flag", 32'(er), 1);
        err_wr = 0;
        access(al(28, 1), 0, 2'd2, 0, rd, er, c);
        chk("R7 err cleared next access", 32'(er), 0);
    endtask

    task automatic t_latency();
        logic [31:0] rd; logic er; int c;
        lat = 1;
        access(al(12, 31), 0, 2'd2, 0, rd, er, c);
        chk("R9 read latency L=1", 32'(c), 3);
        @(negedge clk);
        chk("R8 ready one cycle", 32'(s_ready), 0);
        lat = 4;
        access(al(12, 31), 0, 2'd2, 0, rd, er, c);
        chk("R9 read latency L=4", 32'(c), 6);
        chk("R4 slow read", rd, 1);
        mem[8] = 32'h0;
        access(al(32, 0), 1, 2'd2, 32'h3, rd, er, c);
        chk("R9 write latency L=4", 32'(c), 11);
        chk("R5 set via wdata=3", mem[8], 32'h1);
        lat = 1;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_read();
        t_half_read();
        t_word_read();
        t_upper_ignored();
        t_byte_write();
        t_word_clear();
        t_half_set();
        t_errors();
        t_latency();
        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4ns * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL R8 watchdog expired: actual running expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule